// File: doc/BRIEF.md
# Hub Spike Request Dispatcher

This block is the hub at the centre of a star-shaped cache network. Every spoke ("spike") is a chain of cache banks that starts at the hub. Cache requests arrive on one input port. The hub decodes the target spike from a few low-order address bits, just above the block offset, and writes the request into a small FIFO. Each FIFO drains to its spikes: when the spike named by the request at the head of a FIFO is ready, that request leaves on the spike's issue port.

A FIFO may be private to one spike, or shared by a group of adjacent spikes to save queue storage. The sharing factor is a parameter, and it changes how much requests for different spikes can block one another. In a shared FIFO only the head request can issue. A request for an idle spike therefore waits behind an older request whose spike is stalled. On the return side, replies from all spikes are merged onto one response port by a round-robin arbiter.

Top module: `hub_dispatch`

## Requirements
- R1: After reset every queue is empty: `req_ready` is 1, and all of `spk_valid` and `rsp_in_ready` are 0.
- R2: The target spike of a request is the value of `req_addr[OFFS_W +: log2(NSPK)]`. A request leaves only on that spike's issue port, with its address and data unchanged.
- R3: Spike `s` uses queue `s / SHARE`. A queue that is full or blocked has no effect on acceptance or issue for the spikes of any other queue.
- R4: Requests for the same spike issue in the order in which they were accepted.
- R5: In a shared queue, only the head entry may issue. A request for a ready spike stays unissued while an older entry for a stalled spike is ahead of it, and at most one spike of a group is valid at a time.
- R6: When the queue chosen by `req_addr` holds DEPTH entries, `req_ready` is 0 and the request is not accepted.
- R7: A request accepted into an empty queue is presented on its spike port in the cycle after the accepting clock edge.
- R8: While `spk_valid[s]` is 1 and `spk_ready[s]` is 0, the request stays valid and its address and data do not change.
- R9: `rsp_valid` is the OR of all bits of `rsp_in_valid`. `rsp_data` and `rsp_spike` come from the granted spike. `rsp_in_ready` is one-hot on the granted spike when `rsp_ready` is 1, and all zero when `rsp_ready` is 0.
- R10: Response grants rotate. After spike `g` is served, the search for the next grant starts at spike `g+1` (mod NSPK). After reset the search starts at spike 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Incoming request valid |
| req_ready | output | 1 | Queue for the addressed spike can accept |
| req_addr | input | ADDR_W | Request address (spike index above block offset) |
| req_data | input | DATA_W | Request payload |
| spk_valid | output | NSPK | Per-spike issue valid |
| spk_ready | input | NSPK | Per-spike ready to take a request |
| spk_addr | output | NSPK*ADDR_W | Per-spike issued address, spike s at bits s*ADDR_W |
| spk_data | output | NSPK*DATA_W | Per-spike issued payload |
| rsp_in_valid | input | NSPK | Per-spike reply valid |
| rsp_in_ready | output | NSPK | Per-spike reply accepted |
| rsp_in_data | input | NSPK*DATA_W | Per-spike reply payload |
| rsp_valid | output | 1 | Merged reply valid |
| rsp_ready | input | 1 | Merged reply consumer ready |
| rsp_data | output | DATA_W | Merged reply payload |
| rsp_spike | output | log2(NSPK) | Spike that produced the merged reply |

## Verification
The bench builds the block with four spikes, SHARE of 2, DEPTH of 4, a 2-bit block offset and a 12-bit address. This gives two queues of two spikes each. With these values, head-of-line blocking between two spikes of one group can be reached, and so can independence from the other group. A queue can be filled with only four requests. A shared queue also lets the bench test that each spike keeps its own issue order while the spikes of a group interleave. Four reply sources are enough to show the round-robin pointer skipping an idle spike and wrapping around.

// File: rtl/hub_pkg.sv
package hub_pkg;
   // ceiling log2, never below 1 (for index widths)
   function automatic int unsigned idx_w(input int unsigned v);
      int unsigned r;
      r = 1;
      while ((32'd1 << r) < v) r++;
      return r;
   endfunction

   // exact log2 of a power of two, 0 for 1
   function automatic int unsigned shift_of(input int unsigned v);
      int unsigned r;
      r = 0;
      while ((32'd1 << r) < v) r++;
      return r;
   endfunction

   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction
endpackage

// File: rtl/hub_fifo.sv
module hub_fifo #(
   parameter int unsigned W     = 8,
   parameter int unsigned DEPTH = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] wdata,
   input  logic         pop,
   output logic [W-1:0] rdata,
   output logic         empty,
   output logic         full
);
   localparam int unsigned AW = hub_pkg::idx_w(DEPTH);
   localparam int unsigned CW = hub_pkg::idx_w(DEPTH + 1);

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wp, rp;
   logic [CW-1:0] cnt;
   logic          do_push, do_pop;

   assign empty   = (cnt == '0);
   assign full    = (cnt == CW'(DEPTH));
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign rdata   = mem[rp];

   function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
      return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
   endfunction

   always_ff @(posedge clk) begin
      if (do_push) mem[wp] <= wdata;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (do_push) wp <= bump(wp);
         if (do_pop)  rp <= bump(rp);
         case ({do_push, do_pop})
            2'b10:   cnt <= cnt + CW'(1);
            2'b01:   cnt <= cnt - CW'(1);
            default: cnt <= cnt;
         endcase
      end
   end
endmodule

// File: rtl/hub_rr_arb.sv
module hub_rr_arb #(
   parameter int unsigned N = 4
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic [N-1:0]                   req,
   input  logic                           adv,
   output logic [N-1:0]                   gnt,
   output logic [hub_pkg::idx_w(N)-1:0]   gidx,
   output logic                           any
);
   localparam int unsigned IW = hub_pkg::idx_w(N);

   logic [IW-1:0] ptr;
   logic          found;
   int unsigned   cand;

   assign any = |req;

   always_comb begin
      gnt   = '0;
      gidx  = '0;
      found = 1'b0;
      cand  = 0;
      for (int unsigned i = 0; i < N; i++) begin
         cand = (int'(ptr) + i) % N;
         if (!found && req[cand]) begin
            found     = 1'b1;
            gnt[cand] = 1'b1;
            gidx      = IW'(cand);
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ptr <= '0;
      end else if (adv && any) begin
         ptr <= (gidx == IW'(N - 1)) ? '0 : gidx + IW'(1);
      end
   end
endmodule

// File: rtl/hub_dispatch.sv
module hub_dispatch #(
   parameter int unsigned NSPK   = 4,
   parameter int unsigned SHARE  = 2,
   parameter int unsigned DEPTH  = 4,
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned DATA_W = 16,
   parameter int unsigned OFFS_W = 4
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             req_valid,
   output logic                             req_ready,
   input  logic [ADDR_W-1:0]                req_addr,
   input  logic [DATA_W-1:0]                req_data,
   output logic [NSPK-1:0]                  spk_valid,
   input  logic [NSPK-1:0]                  spk_ready,
   output logic [NSPK*ADDR_W-1:0]           spk_addr,
   output logic [NSPK*DATA_W-1:0]           spk_data,
   input  logic [NSPK-1:0]                  rsp_in_valid,
   output logic [NSPK-1:0]                  rsp_in_ready,
   input  logic [NSPK*DATA_W-1:0]           rsp_in_data,
   output logic                             rsp_valid,
   input  logic                             rsp_ready,
   output logic [DATA_W-1:0]                rsp_data,
   output logic [hub_pkg::idx_w(NSPK)-1:0]  rsp_spike
);
   localparam int unsigned SPK_W = hub_pkg::idx_w(NSPK);
   localparam int unsigned NQ    = NSPK / SHARE;
   localparam int unsigned QW    = hub_pkg::idx_w(NQ);
   localparam int unsigned GSH   = hub_pkg::shift_of(SHARE);
   localparam int unsigned GRP_W = (SHARE > 1) ? GSH : 1;
   localparam int unsigned EW    = ADDR_W + DATA_W;

   // elaboration-time parameter checks
   if (NSPK < 2 || !hub_pkg::is_pow2(NSPK)) begin : g_bad_nspk
      $error("NSPK must be a power of two, at least 2");
   end
   if (SHARE < 1 || SHARE > NSPK || !hub_pkg::is_pow2(SHARE)) begin : g_bad_share
      $error("SHARE must be a power of two no larger than NSPK");
   end
   if (DEPTH < 1) begin : g_bad_depth
      $error("DEPTH must be at least 1");
   end
   if (OFFS_W + SPK_W > ADDR_W) begin : g_bad_addr
      $error("spike index field does not fit in the address");
   end

   // request side decode
   logic [SPK_W-1:0] req_spk;
   logic [QW-1:0]    req_q;
   assign req_spk = req_addr[OFFS_W +: SPK_W];
   assign req_q   = QW'(req_spk >> GSH);

   logic [NQ-1:0]    q_empty, q_full, q_pop;
   logic [EW-1:0]    q_head [NQ];
   logic [NSPK-1:0]  spk_fire;

   assign req_ready = !q_full[req_q];
   assign spk_fire  = spk_valid & spk_ready;

   for (genvar q = 0; q < NQ; q++) begin : g_queue
      logic q_push;
      assign q_push   = req_valid && (req_q == QW'(q));
      assign q_pop[q] = |spk_fire[q*SHARE +: SHARE];

      hub_fifo #(.W(EW), .DEPTH(DEPTH)) u_fifo (
         .clk   (clk),
         .rst_n (rst_n),
         .push  (q_push),
         .wdata ({req_addr, req_data}),
         .pop   (q_pop[q]),
         .rdata (q_head[q]),
         .empty (q_empty[q]),
         .full  (q_full[q])
      );
   end

   // issue side: each spike watches the head of its queue
   for (genvar s = 0; s < NSPK; s++) begin : g_spike
      localparam int unsigned QI = s / SHARE;
      localparam int unsigned MI = s % SHARE;
      logic [ADDR_W-1:0] head_addr;
      assign head_addr = q_head[QI][EW-1:DATA_W];

      if (SHARE == 1) begin : g_private
         assign spk_valid[s] = !q_empty[QI];
      end else begin : g_shared
         logic [GRP_W-1:0] head_member;
         assign head_member  = head_addr[OFFS_W +: GRP_W];
         assign spk_valid[s] = !q_empty[QI] && (head_member == GRP_W'(MI));
      end

      assign spk_addr[s*ADDR_W +: ADDR_W] = head_addr;
      assign spk_data[s*DATA_W +: DATA_W] = q_head[QI][DATA_W-1:0];
   end

   // return side: round-robin merge
   logic [NSPK-1:0]  gnt;
   logic [SPK_W-1:0] gidx;
   logic             any_rsp;

   hub_rr_arb #(.N(NSPK)) u_arb (
      .clk   (clk),
      .rst_n (rst_n),
      .req   (rsp_in_valid),
      .adv   (rsp_ready),
      .gnt   (gnt),
      .gidx  (gidx),
      .any   (any_rsp)
   );

   assign rsp_valid    = any_rsp;
   assign rsp_in_ready = gnt & {NSPK{rsp_ready}};
   assign rsp_data     = rsp_in_data[gidx*DATA_W +: DATA_W];
   assign rsp_spike    = gidx;
endmodule

// File: rtl/hub_dispatch_chk.sv
module hub_dispatch_chk #(
   parameter int unsigned NSPK   = 4,
   parameter int unsigned SHARE  = 2,
   parameter int unsigned DEPTH  = 4,
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned DATA_W = 16,
   parameter int unsigned OFFS_W = 4
) (
   input logic                             clk,
   input logic                             rst_n,
   input logic                             req_valid,
   input logic                             req_ready,
   input logic [ADDR_W-1:0]                req_addr,
   input logic [DATA_W-1:0]                req_data,
   input logic [NSPK-1:0]                  spk_valid,
   input logic [NSPK-1:0]                  spk_ready,
   input logic [NSPK*ADDR_W-1:0]           spk_addr,
   input logic [NSPK*DATA_W-1:0]           spk_data,
   input logic [NSPK-1:0]                  rsp_in_valid,
   input logic [NSPK-1:0]                  rsp_in_ready,
   input logic [NSPK*DATA_W-1:0]           rsp_in_data,
   input logic                             rsp_valid,
   input logic                             rsp_ready,
   input logic [DATA_W-1:0]                rsp_data,
   input logic [hub_pkg::idx_w(NSPK)-1:0]  rsp_spike
);
   localparam int unsigned SPK_W = hub_pkg::idx_w(NSPK);
   localparam int unsigned NQ    = NSPK / SHARE;
   localparam int unsigned CW    = hub_pkg::idx_w(DEPTH + 1);

   logic [SPK_W-1:0] tgt_spk;
   assign tgt_spk = req_addr[OFFS_W +: SPK_W];

   AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> req_ready && (spk_valid == '0) && (rsp_in_ready == '0)); // R1

   AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(rsp_in_ready)); // R9

   AST_MERGE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid == (|rsp_in_valid)); // R9

   for (genvar s = 0; s < NSPK; s++) begin : g_s
      AST_SPIKE_DECODE: assert property (@(posedge clk) disable iff (!rst_n)
         spk_valid[s] |-> (spk_addr[s*ADDR_W + OFFS_W +: SPK_W] == SPK_W'(s))); // R2

      AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
         spk_valid[s] && !spk_ready[s] |=> spk_valid[s]
            && $stable(spk_addr[s*ADDR_W +: ADDR_W])
            && $stable(spk_data[s*DATA_W +: DATA_W])); // R8

      AST_GRANT_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
         rsp_in_ready[s] |-> rsp_in_valid[s] && rsp_ready && (rsp_spike == SPK_W'(s))); // R9
   end

   for (genvar q = 0; q < NQ; q++) begin : g_q
      logic [CW-1:0] occ;
      logic          in_q, out_q;
      assign in_q  = req_valid && req_ready && (int'(tgt_spk) / SHARE == q);
      assign out_q = |(spk_valid[q*SHARE +: SHARE] & spk_ready[q*SHARE +: SHARE]);

      always_ff @(posedge clk) begin
         if (!rst_n) occ <= '0;
         else occ <= occ + CW'(in_q) - CW'(out_q);
      end

      AST_ONE_PER_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
         $onehot0(spk_valid[q*SHARE +: SHARE])); // R5

      AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
         occ <= CW'(DEPTH)); // R6

      AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
         (occ == CW'(DEPTH)) && (int'(tgt_spk) / SHARE == q) |-> !req_ready); // R6

      AST_EMPTY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
         (occ == '0) |-> (spk_valid[q*SHARE +: SHARE] == '0)); // R7
   end
endmodule

bind hub_dispatch hub_dispatch_chk #(
   .NSPK(NSPK), .SHARE(SHARE), .DEPTH(DEPTH),
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFFS_W(OFFS_W)
) u_chk (.*);

// File: tb/tb_hub_dispatch.sv
module tb_hub_dispatch;
   localparam int NS = 4, SH = 2, DP = 4, AW = 12, DW = 16, OW = 2;

   logic            clk = 0, rst_n = 0;
   logic            req_valid = 0, req_ready;
   logic [AW-1:0]   req_addr = '0;
   logic [DW-1:0]   req_data = '0;
   logic [NS-1:0]   spk_valid, spk_ready = '0;
   logic [NS*AW-1:0] spk_addr;
   logic [NS*DW-1:0] spk_data;
   logic [NS-1:0]   rsp_in_valid = '0, rsp_in_ready;
   logic [NS*DW-1:0] rsp_in_data;
   logic            rsp_valid, rsp_ready = 0;
   logic [DW-1:0]   rsp_data;
   logic [1:0]      rsp_spike;

   always #2 clk = ~clk;

   for (genvar s = 0; s < NS; s++) begin : g_rd
      assign rsp_in_data[s*DW +: DW] = 16'hC000 + DW'(s);
   end

   hub_dispatch #(.NSPK(NS), .SHARE(SH), .DEPTH(DP), .ADDR_W(AW), .DATA_W(DW), .OFFS_W(OW)) dut (.*);

   int ncmp = 0, nfail = 0;
   bit done = 0, rsp_phase = 0, rnd_on = 0;
   int rptr = 0;
   logic [AW+DW-1:0] expq [NS][$];

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      ncmp++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic [AW-1:0] mk(input int sp, input int tag);
      return {8'(tag), 2'(sp), 2'b01};
   endfunction

   // scoreboard monitor for the issue ports
   always @(negedge clk) begin
      if (rst_n) begin
         for (int s = 0; s < NS; s++) begin
            if (spk_valid[s] && spk_ready[s]) begin
               logic [AW+DW-1:0] got, e;
               got = {spk_addr[s*AW +: AW], spk_data[s*DW +: DW]};
               chk(spk_addr[s*AW + OW +: 2] == 2'(s), "R2", "spike field", 64'(got), 64'(s));
               if (expq[s].size() == 0) chk(0, "R6", "unexpected issue", 64'(got), 0);
               else begin
                  e = expq[s].pop_front();
                  chk(got == e, "R4", "issued entry", 64'(got), 64'(e));
               end
            end
         end
      end
   end

   // response monitor with its own rotation model
   always @(negedge clk) begin
      if (rst_n && rsp_phase) begin
         chk(rsp_valid == (|rsp_in_valid), "R9", "rsp_valid", 64'(rsp_valid), 64'(|rsp_in_valid));
         if (|rsp_in_valid) begin
            int g;
            g = -1;
            for (int i = 0; i < NS; i++)
               if (g < 0 && rsp_in_valid[(rptr + i) % NS]) g = (rptr + i) % NS;
            if (rsp_ready) begin
               chk(rsp_in_ready == NS'(1 << g) && rsp_spike == 2'(g) && rsp_data == 16'hC000 + DW'(g),
                   "R10", "rr grant", 64'({rsp_in_ready, rsp_spike, rsp_data}),
                   64'({4'(1 << g), 2'(g), 16'hC000 + 16'(g)}));
               rptr = (g + 1) % NS;
            end else begin
               chk(rsp_in_ready == '0, "R9", "no grant while stalled", 64'(rsp_in_ready), 0);
            end
         end
      end
   end

   task automatic send(input int sp, input int tag);
      @(posedge clk); #1;
      req_valid = 1;
      req_addr  = mk(sp, tag);
      req_data  = 16'(tag * 37 + sp);
      do @(negedge clk); while (!req_ready);
      expq[sp].push_back({req_addr, req_data});
      @(posedge clk); #1;
      req_valid = 0;
   endtask

   task automatic drain(input string req);
      spk_ready = '1;
      repeat (DP * NS + 4) @(posedge clk);
      @(negedge clk);
      for (int s = 0; s < NS; s++)
         chk(expq[s].size() == 0, req, "queue drained", 64'(expq[s].size()), 0);
   endtask

   task automatic summary;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nfail);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         nfail++;
         $display("FAIL watchdog: actual hung expected finished");
         summary();
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      @(negedge clk);
      chk(req_ready == 1 && spk_valid == '0 && rsp_in_ready == '0, "R1", "reset state",
          64'({req_ready, spk_valid, rsp_in_ready}), 64'({1'b1, 4'h0, 4'h0}));

      // R7: one-cycle presentation to an idle queue
      send(3, 5);
      @(negedge clk);
      chk(spk_valid == 4'b1000 && spk_addr[3*AW +: AW] == mk(3, 5), "R7", "presented next cycle",
          64'({spk_valid, spk_addr[3*AW +: AW]}), 64'({4'b1000, mk(3, 5)}));
      drain("R7");

      // R5 / R3: head-of-line blocking in queue 0, queue 1 unaffected
      spk_ready = 4'b0110;
      send(0, 1); send(1, 2); send(2, 3);
      repeat (4) @(posedge clk);
      @(negedge clk);
      chk(spk_valid[1] == 0, "R5", "spike1 blocked behind spike0", 64'(spk_valid), 64'(4'b0001));
      chk(expq[1].size() == 1, "R5", "spike1 not issued", 64'(expq[1].size()), 1);
      chk(expq[2].size() == 0, "R3", "other group issued", 64'(expq[2].size()), 0);
      drain("R5");

      // R6 / R3: fill queue 0, hold a fifth request, other queue still open
      spk_ready = '0;
      send(0, 10); send(1, 11); send(0, 12); send(1, 13);
      @(posedge clk); #1;
      req_valid = 1; req_addr = mk(0, 14); req_data = 16'h7777;
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         chk(req_ready == 0, "R6", "full queue refuses", 64'(req_ready), 0);
      end
      @(posedge clk); #1;
      req_valid = 0; req_addr = mk(2, 15);
      @(negedge clk);
      chk(req_ready == 1, "R3", "other queue accepts", 64'(req_ready), 1);
      drain("R6");

      // R8 / R4 / R2: random traffic with random spike readiness
      rnd_on = 1;
      fork
         begin
            for (int n = 0; n < 60; n++) send(int'($urandom % NS), 20 + n);
            rnd_on = 0;
         end
         begin
            while (rnd_on) begin
               @(posedge clk); #1;
               spk_ready = 4'($urandom);
            end
         end
      join
      drain("R4");

      // R9 / R10: merged responses
      rsp_phase = 1;
      @(posedge clk); #1;
      rsp_in_valid = 4'b1101; rsp_ready = 1;
      repeat (8) @(posedge clk);
      #1 rsp_in_valid = 4'b1111;
      for (int i = 0; i < 24; i++) begin
         @(posedge clk); #1;
         rsp_ready = 1'($urandom);
      end
      rsp_in_valid = 4'b0000;
      @(negedge clk);
      rsp_phase = 0;

      done = 1;
      summary();
      $finish;
   end
endmodule